// File: doc/BRIEF.md
# Programmable-Ratio Sinc-Cubed Decimator

This block converts the one-bit stream of a sigma-delta modulator into 16-bit two's complement samples at a lower rate. It uses a cascaded integrator-comb structure of order three. Each accepted input bit counts as +1 when high and -1 when low. Three running integrators accumulate those values at the bit rate. Once every N accepted bits, three first-difference comb stages turn the last integrator value into one filtered sample. The result has the response ((1 - z^-N)/(1 - z^-1))^3.

The decimation ratio N is picked at run time from 32, 64, 128 and 256. The full-precision result grows by log2(N) bits per stage, so the output stage rescales it to a fixed 16-bit word:
- A full-scale input of plus or minus N^3 maps to plus or minus 32768.
- At high ratios the low bits are dropped.
- The one positive value that would overflow is clipped.

In mixed mode the word carries a 15-bit sample under a one-bit control/data flag. A ratio change is held back until the current decimation period ends. The first three samples after a reset or a ratio change are marked as not yet settled.

Top module: `sinc3_decim`

## Requirements
- R1: Let bit index n be the bit accepted on the edge that completes a period. The sample for that period is y = sum over j of h[j]*x[n-3-j]. Here x is +1 for a high bit and -1 for a low bit, and bits before the last reset count as 0. The taps h[j] are the number of triples (a,b,c), each in 0..N-1, with a+b+c = j.
- R2: The code on `ratio_code` sets N = 32 * 2^code (0 gives 32, 1 gives 64, 2 gives 128, 3 gives 256). `smp_vld` is high for exactly one cycle. It rises once per N accepted bits, in the cycle after the edge that accepts the Nth bit.
- R3: y is first clipped to at most N^3 - 1. It is then shifted right arithmetically by 3*log2(N) - 15, which rounds toward minus infinity, and the result is `smp_out` as a 16-bit two's complement word. When the shift count is negative (output wider than the growth), the word is shifted left with zero fill.
- R4: Integrators and combs wrap modulo 2^26. Samples stay correct however long the stream runs.
- R5: When `mix_mode` is 1, bit 15 of `smp_out` equals `ctl_flag` as sampled on the output edge. Bits 14..0 equal bits 15..1 of the R3 word.
- R6: A new `ratio_code` is ignored until the current period ends. The sample that closes that period is spaced and scaled by the old ratio, and the following periods use the new one.
- R7: `smp_ok` is 0 on the first three samples after a reset and after each adoption of a new ratio. It is 1 on every other sample.
- R8: A synchronous reset clears the integrators, the comb delays, the bit counter and all outputs. It also loads `ratio_code` as the active ratio. The first period after reset counts N bits from the release of reset.
- R9: A cycle with `bit_en` low accepts no bit. `smp_out` and `smp_ok` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| ratio_code | input | 2 | Decimation ratio select, N = 32 * 2^code |
| mix_mode | input | 1 | Selects the 15-bit flagged word format |
| ctl_flag | input | 1 | Flag placed in the MSB in mixed mode |
| smp_out | output | 16 | Registered two's complement sample |
| smp_vld | output | 1 | One-cycle strobe for a new sample |
| smp_ok | output | 1 | Sample is past the settling window |

## Verification
The bench builds the block with its default parameters: a 16-bit word and ratio exponents 5 through 8. That makes all four ratios reachable, each with its own shift count, so every ratio is swept.

Each ratio is run with several streams:
- random bits;
- all ones, which reaches the clip at +N^3;
- all zeros, which reaches exactly -32768;
- an alternating pattern;
- a slow square wave;
- streams with idle cycles in between.

Each sample is compared against a direct convolution with taps computed arithmetically in the bench. Runs of several hundred to a few thousand bits drive the integrators through the 26-bit wrap. Mid-stream ratio changes exercise the deferred adoption and the settling flag.

// File: rtl/sinc3_pkg.sv
`timescale 1ns/1ps
package sinc3_pkg;
  // Order of the filter: integrator and comb stages each.
  localparam int STAGES = 3;

  // Ratio exponent for a given select code.
  function automatic int ratio_log(input int min_log, input int code);
    return min_log + code;
  endfunction
endpackage

// File: rtl/sinc3_integ.sv
`timescale 1ns/1ps
module sinc3_integ
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             bit_in,
  output logic [ACC_W-1:0] acc_out
);
  logic [STAGES-1:0][ACC_W-1:0] acc;
  logic [ACC_W-1:0]             step;

  // High bit adds one, low bit adds minus one (all ones).
  assign step = bit_in ? ACC_W'(1) : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en) begin
      for (int s = 0; s < STAGES; s++) begin
        // Each stage accumulates the previous stage's registered value.
        acc[s] <= acc[s] + ((s == 0) ? step : acc[(s == 0) ? 0 : s-1]);
      end
    end
  end

  assign acc_out = acc[STAGES-1];
endmodule

// File: rtl/sinc3_comb.sv
`timescale 1ns/1ps
module sinc3_comb
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] dout
);
  logic [ACC_W-1:0] dly   [STAGES];
  logic [ACC_W-1:0] chain [STAGES+1];

  assign chain[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_diff
    // First difference at the decimated rate; wrap-around is intended.
    assign chain[s+1] = chain[s] - dly[s];

    always_ff @(posedge clk) begin
      if (rst) begin
        dly[s] <= '0;
      end else if (tick) begin
        dly[s] <= chain[s];
      end
    end
  end

  assign dout = chain[STAGES];
endmodule

// File: rtl/sinc3_ctrl.sv
`timescale 1ns/1ps
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int MIN_LOG = 5,
  parameter int MAX_LOG = 8,
  parameter int CODE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              tick,
  output logic [CODE_W-1:0] act_code,
  output logic              settled
);
  localparam int NCODE  = MAX_LOG - MIN_LOG + 1;
  localparam int CNT_W  = MAX_LOG;
  localparam int HOLD_W = $clog2(STAGES + 1);

  logic [CNT_W-1:0]  lim [NCODE];
  logic [CNT_W-1:0]  cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic              code_ok;

  for (genvar c = 0; c < NCODE; c++) begin : g_lim
    assign lim[c] = CNT_W'((1 << ratio_log(MIN_LOG, c)) - 1);
  end

  assign code_ok = {1'b0, ratio_code} < (CODE_W+1)'(NCODE);
  assign tick    = bit_en && (cnt == lim[act_code]);
  assign settled = (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      act_code <= code_ok ? ratio_code : '0;
      hold_cnt <= HOLD_W'(STAGES);
    end else if (tick) begin
      cnt <= '0;
      if (code_ok && (ratio_code != act_code)) begin
        // New ratio starts with the next period; comb history is stale.
        act_code <= ratio_code;
        hold_cnt <= HOLD_W'(STAGES);
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - HOLD_W'(1);
      end
    end else if (bit_en) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sinc3_align.sv
`timescale 1ns/1ps
module sinc3_align
  import sinc3_pkg::*;
#(
  parameter int OUT_W   = 16,
  parameter int MIN_LOG = 5,
  parameter int MAX_LOG = 8,
  parameter int ACC_W   = 26,
  parameter int CODE_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ACC_W-1:0]  y,
  input  logic [CODE_W-1:0] code,
  input  logic              mix,
  input  logic              flag,
  input  logic              settled,
  output logic [OUT_W-1:0]  smp_out,
  output logic              smp_vld,
  output logic              smp_ok
);
  localparam int NCODE = MAX_LOG - MIN_LOG + 1;

  logic signed [ACC_W-1:0] ys;
  logic [OUT_W-1:0]        word [NCODE];
  logic [OUT_W-1:0]        sel;
  logic [OUT_W-1:0]        nxt;

  assign ys = signed'(y);

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    localparam int GROW = STAGES * ratio_log(MIN_LOG, c);
    localparam int SH   = GROW - (OUT_W - 1);
    localparam logic signed [ACC_W-1:0] TOP = ACC_W'((64'd1 << GROW) - 64'd1);

    logic signed [ACC_W-1:0] clip;
    assign clip = (ys > TOP) ? TOP : ys;

    if (SH >= 0) begin : g_trunc
      assign word[c] = OUT_W'(clip >>> SH);
    end else begin : g_pad
      assign word[c] = OUT_W'(clip) << (-SH);
    end
  end

  assign sel = word[code];
  assign nxt = mix ? {flag, sel[OUT_W-1:1]} : sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_out <= '0;
      smp_vld <= 1'b0;
      smp_ok  <= 1'b0;
    end else begin
      smp_vld <= tick;
      if (tick) begin
        smp_out <= nxt;
        smp_ok  <= settled;
      end
    end
  end
endmodule

// File: rtl/sinc3_decim.sv
`timescale 1ns/1ps
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int OUT_W   = 16,
  parameter int MIN_LOG = 5,
  parameter int MAX_LOG = 8,
  localparam int CODE_W = $clog2(MAX_LOG - MIN_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              mix_mode,
  input  logic              ctl_flag,
  output logic [OUT_W-1:0]  smp_out,
  output logic              smp_vld,
  output logic              smp_ok
);
  // Growth of STAGES*MAX_LOG bits plus sign and the +N^3 extreme.
  localparam int ACC_W = STAGES * MAX_LOG + 2;

  logic [ACC_W-1:0]  integ_q;
  logic [ACC_W-1:0]  comb_y;
  logic              tick;
  logic [CODE_W-1:0] act_code;
  logic              settled;

  sinc3_integ #(.ACC_W(ACC_W)) integ_i (
    .clk(clk), .rst(rst), .en(bit_en), .bit_in(bit_in), .acc_out(integ_q)
  );

  sinc3_ctrl #(.MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .CODE_W(CODE_W)) ctrl_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ratio_code(ratio_code),
    .tick(tick), .act_code(act_code), .settled(settled)
  );

  sinc3_comb #(.ACC_W(ACC_W)) comb_i (
    .clk(clk), .rst(rst), .tick(tick), .din(integ_q), .dout(comb_y)
  );

  sinc3_align #(
    .OUT_W(OUT_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG),
    .ACC_W(ACC_W), .CODE_W(CODE_W)
  ) align_i (
    .clk(clk), .rst(rst), .tick(tick), .y(comb_y), .code(act_code),
    .mix(mix_mode), .flag(ctl_flag), .settled(settled),
    .smp_out(smp_out), .smp_vld(smp_vld), .smp_ok(smp_ok)
  );
endmodule

// File: rtl/sinc3_decim_chk.sv
`timescale 1ns/1ps
module sinc3_decim_chk #(
  parameter int OUT_W   = 16,
  parameter int MIN_LOG = 5,
  parameter int MAX_LOG = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             mix_mode,
  input logic             ctl_flag,
  input logic [OUT_W-1:0] smp_out,
  input logic             smp_vld,
  input logic             smp_ok
);
  localparam int SEEN_W = MAX_LOG + 2;
  localparam logic [SEEN_W-1:0] MIN_N = SEEN_W'(1 << MIN_LOG);
  localparam logic [SEEN_W-1:0] MAX_N = SEEN_W'(1 << MAX_LOG);

  logic [SEEN_W-1:0] bits_seen;
  logic [1:0]        vld_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_seen <= '0;
      vld_cnt   <= '0;
    end else begin
      if (smp_vld) bits_seen <= bit_en ? SEEN_W'(1) : '0;
      else if (bit_en) bits_seen <= bits_seen + SEEN_W'(1);
      if (smp_vld && vld_cnt != 2'd3) vld_cnt <= vld_cnt + 2'd1;
    end
  end

  assert_vld_single_R2: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> !smp_vld);

  assert_vld_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> ($countones(bits_seen) == 1 && bits_seen >= MIN_N && bits_seen <= MAX_N));

  assert_vld_after_bit_R9: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> $past(bit_en));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld && !$past(rst)) |-> ($stable(smp_out) && $stable(smp_ok)));

  assert_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && $past(mix_mode)) |-> (smp_out[OUT_W-1] == $past(ctl_flag)));

  assert_settle_R7: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && vld_cnt < 2'd3) |-> !smp_ok);

  assert_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (smp_out == '0 && !smp_vld && !smp_ok));
endmodule

bind sinc3_decim sinc3_decim_chk #(
  .OUT_W(OUT_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)
) chk_i (
  .clk(clk), .rst(rst), .bit_en(bit_en), .mix_mode(mix_mode),
  .ctl_flag(ctl_flag), .smp_out(smp_out), .smp_vld(smp_vld), .smp_ok(smp_ok)
);

// File: tb/sinc3_decim_tb_top.sv
`timescale 1ns/1ps
module sinc3_decim_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_LOG = 5;
  localparam int MAX_LOG = 8;
  localparam int NCODE   = MAX_LOG - MIN_LOG + 1;
  localparam int HMAX    = 3 * (1 << MAX_LOG);
  localparam int HIST    = 8192;

  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, bit_in = 1'b0;
  logic mix_mode = 1'b0, ctl_flag = 1'b0;
  logic [1:0]  ratio_code = 2'd0;
  logic [15:0] smp_out;
  logic        smp_vld, smp_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  sinc3_decim dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .ratio_code(ratio_code), .mix_mode(mix_mode), .ctl_flag(ctl_flag),
    .smp_out(smp_out), .smp_vld(smp_vld), .smp_ok(smp_ok)
  );

  int     total = 0, bad = 0;
  longint hh [NCODE][HMAX];
  bit     hist [HIST];
  int     nbits = 0, last_n = -1, since = 0, vld_seen = 0;
  int     act_code = 0, new_code = 0;
  bit     chg_req = 1'b0, after_chg = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Taps: count of triples in [0,N)^3 summing to j, via a triangle convolution.
  initial begin
    for (int c = 0; c < NCODE; c++) begin
      int n;
      n = 1 << (MIN_LOG + c);
      for (int j = 0; j < HMAX; j++) begin
        longint s;
        s = 0;
        for (int a = 0; a < n; a++) begin
          int k;
          k = j - a;
          if (k >= 0 && k <= 2*n - 2) s += n - ((k > n-1) ? (k - (n-1)) : ((n-1) - k));
        end
        hh[c][j] = s;
      end
    end
  end

  // Monitor: sample away from the rising edge.
  always @(negedge clk) begin
    if (!rst && smp_vld) begin
      int n, lg, nn, sh;
      longint y, top, w;
      logic [15:0] ew;
      n  = nbits - (bit_en ? 1 : 0) - 1;
      lg = MIN_LOG + act_code;
      nn = 1 << lg;
      check(n - last_n == nn, chg_req ? "R6 spacing before adoption" : "R2 strobe spacing",
            n - last_n, nn);
      check(smp_ok == (since >= 3), "R7 settle flag", smp_ok, since >= 3);
      if (!after_chg || since >= 3) begin
        y = 0;
        for (int j = 0; j <= 3*nn - 3; j++) begin
          int idx;
          idx = n - 3 - j;
          if (idx >= 0 && idx < HIST) y += hist[idx] ? hh[act_code][j] : -hh[act_code][j];
        end
        top = (64'sd1 <<< (3*lg)) - 1;
        if (y > top) y = top;
        sh = 3*lg - 15;
        w  = y >>> sh;
        ew = w[15:0];
        if (mix_mode) ew = {ctl_flag, ew[15:1]};
        check(smp_out == ew, mix_mode ? "R5 mixed word" : "R1 R3 R4 R9 sample value",
              smp_out, ew);
      end
      vld_seen++;
      last_n = n;
      since++;
      if (chg_req) begin
        act_code  = new_code;
        since     = 0;
        after_chg = 1'b1;
        chg_req   = 1'b0;
      end
    end
  end

  task automatic do_reset(input int code, input bit mix, input bit flag);
    @(posedge clk); #(CLK_PERIOD/4);
    rst = 1'b1; bit_en = 1'b0; ratio_code = 2'(code); mix_mode = mix; ctl_flag = flag;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    check(smp_out == 16'd0 && !smp_vld && !smp_ok, "R8 reset state",
          {smp_out, smp_vld, smp_ok}, 0);
    nbits = 0; last_n = -1; since = 0; vld_seen = 0;
    act_code = code; after_chg = 1'b0; chg_req = 1'b0;
    rst = 1'b0;
  endtask

  // pat: 0 random, 1 ones, 2 zeros, 3 alternating, 4 slow square
  task automatic feed_until(input int target, input int pat, input bit gaps);
    forever begin
      @(posedge clk); #(CLK_PERIOD/4);
      if (vld_seen >= target) begin
        bit_en = 1'b0;
        break;
      end
      if (!gaps || $urandom_range(0, 3) != 0) begin
        bit b;
        case (pat)
          0: b = 1'($urandom_range(0, 1));
          1: b = 1'b1;
          2: b = 1'b0;
          3: b = 1'(nbits % 2);
          default: b = 1'((nbits / 40) % 2);
        endcase
        bit_en = 1'b1;
        bit_in = b;
        if (nbits < HIST) hist[nbits] = b;
        nbits++;
      end else begin
        bit_en = 1'b0;
      end
    end
  endtask

  task automatic request_code(input int code);
    ratio_code = 2'(code);
    new_code   = code;
    chg_req    = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", vld_seen, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    // Sweep every ratio against every stimulus pattern.
    for (int c = 0; c < NCODE; c++) begin
      for (int p = 0; p < 5; p++) begin
        do_reset(c, 1'b0, 1'b0);
        feed_until(7, p, (p == 0 || p == 4));
      end
    end
    // Mixed control/data word format.
    do_reset(1, 1'b1, 1'b1);
    feed_until(6, 0, 1'b0);
    do_reset(3, 1'b1, 1'b0);
    feed_until(5, 2, 1'b0);
    // Ratio changes mid-stream.
    do_reset(0, 1'b0, 1'b0);
    feed_until(5, 0, 1'b0);
    request_code(2);
    feed_until(12, 0, 1'b0);
    request_code(3);
    feed_until(17, 4, 1'b1);
    request_code(1);
    feed_until(24, 0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule